// File: doc/BRIEF.md
# TCE DMA Address Translator

This block translates I/O bus addresses issued by DMA-capable devices into physical addresses. It keeps a table of 64-bit translation control entries (TCEs) in on-chip registers. A window of the I/O bus, set by a base offset, a page shift and an entry count, maps onto that table. The table index is the distance from the window base, shifted right by the page shift. Each entry holds the physical page address in its upper bits and a two-bit access permission in its lowest bits.

A lookup port accepts an address and an access direction. One cycle later it returns the translated page address, the stored permission and a fault flag. A separate single-entry port lets system software read or write one entry, selected by I/O bus address, and reports success or a parameter error. Every successful entry write also sends an update notification, so that downstream translation consumers can drop stale mappings. An enable command loads the window configuration. A clear input zeroes the entries and keeps the configuration. A disable command zeroes both.

Top module: `tce_xlate_top`

## Requirements
- R1: After reset every output is zero, the entry count is zero, and every lookup returns a fault.
- R2: An enable command (`cfg_en`) loads base, page shift and entry count only while the current count is zero; otherwise it is ignored. A count above the table depth is capped to the depth. If `cfg_dis` is high in the same cycle, disable wins.
- R3: The entry index is (address minus base) shifted right by the page shift, using modulo 2^AW arithmetic. The index is in range only when it is below the entry count, so addresses below the base are out of range.
- R4: A lookup (`lk_valid`) answers exactly one cycle later on `lk_done`. `lk_phys` is the entry ANDed with the page mask, ~(2^shift − 1). `lk_perm` is entry bits [1:0], coded 0 = none, 1 = read-only, 2 = write-only, 3 = read-write.
- R5: `lk_fault` is set when the index is out of range, and `lk_phys` and `lk_perm` are then zero. It is also set when the access is not allowed: a read (`lk_write`=0) needs entry bit 0, and a write (`lk_write`=1) needs entry bit 1.
- R6: A single-entry write first aligns the address down to a page boundary, then computes the index. If the index is in range, the entry is stored and `rg_err` is 0. If it is out of range, nothing is stored and `rg_err` is 1. The response appears on `rg_done` one cycle later.
- R7: A single-entry read returns the stored entry on `rg_rdata` with `rg_err` 0. If the index is out of range, it returns `rg_err` 1 and `rg_rdata` 0.
- R8: One cycle after each successful write, `nt_valid` pulses. `nt_page` carries (aligned address − base) ANDed with the page mask, `nt_phys` the entry ANDed with the page mask, `nt_mask` the inverse of the page mask, and `nt_perm` entry bits [1:0]. A rejected write raises no notification.
- R9: When a lookup and a successful write hit the same index in the same cycle, the lookup returns the newly written entry.
- R10: `tbl_clr` zeroes every entry and keeps the base, page shift and count.
- R11: `cfg_dis` zeroes every entry and sets base, page shift and count to zero, after which every access is out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Load window configuration |
| cfg_dis | input | 1 | Disable: clear table and configuration |
| cfg_base | input | AW | Window base offset |
| cfg_shift | input | SW | Page shift |
| cfg_count | input | IW+1 | Number of entries |
| tbl_clr | input | 1 | Zero all entries, keep configuration |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup access type, 1 = write |
| lk_addr | input | AW | Lookup I/O bus address |
| lk_done | output | 1 | Lookup response valid |
| lk_phys | output | EW | Translated page address |
| lk_perm | output | 2 | Entry permission |
| lk_fault | output | 1 | Lookup faulted |
| rg_valid | input | 1 | Single-entry access request |
| rg_wr | input | 1 | 1 = write, 0 = read |
| rg_addr | input | AW | I/O bus address of the entry |
| rg_wdata | input | EW | Entry to write |
| rg_done | output | 1 | Access response valid |
| rg_err | output | 1 | Parameter error (index out of range) |
| rg_rdata | output | EW | Entry read |
| nt_valid | output | 1 | Update notification |
| nt_page | output | AW | I/O page offset within the window |
| nt_phys | output | EW | Translated page address |
| nt_mask | output | EW | In-page offset mask |
| nt_perm | output | 2 | Decoded permission |

## Verification
The hardest case to reach from the ports is a lookup and a write that land on the same index in the same cycle, where the write must win. The stimulus pairs a register write with a lookup to a different address inside the same page, so the two hit the same entry in one cycle. Window edges are reached with directed stimulus: an index equal to the count, an address one below the base, and an unaligned write address. Random operations then run in a window whose base is not page-aligned and whose pages are larger.

// File: rtl/iotx_pkg.sv
package iotx_pkg;
    parameter int IOA_W   = 32;
    parameter int ENT_W   = 64;
    parameter int IDX_W   = 6;
    parameter int SHIFT_W = 5;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RO   = 2'd1,
        PERM_WO   = 2'd2,
        PERM_RW   = 2'd3
    } perm_e;

    typedef struct packed {
        logic [ENT_W-1:0] phys;
        perm_e            perm;
        logic             fault;
    } xlate_rsp_t;

    function automatic logic [ENT_W-1:0] page_mask(input logic [SHIFT_W-1:0] sh);
        return ~((ENT_W'(1) << sh) - ENT_W'(1));
    endfunction

    function automatic logic access_denied(input logic [1:0] perm, input logic is_wr);
        return is_wr ? ~perm[1] : ~perm[0];
    endfunction
endpackage

// File: rtl/iotx_index.sv
module iotx_index #(
    parameter int AW    = iotx_pkg::IOA_W,
    parameter int IW    = iotx_pkg::IDX_W,
    parameter int SW    = iotx_pkg::SHIFT_W,
    parameter bit ALIGN = 1'b0
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [SW-1:0] shift,
    input  logic [IW:0]   count,
    output logic [IW-1:0] idx,
    output logic          hit,
    output logic [AW-1:0] offs
);
    logic [AW-1:0] src;
    logic [AW-1:0] full;

    generate
        if (ALIGN) begin : g_align
            assign src = addr & ~((AW'(1) << shift) - AW'(1));
        end else begin : g_raw
            assign src = addr;
        end
    endgenerate

    assign offs = src - base;
    assign full = offs >> shift;
    assign hit  = full < AW'(count);
    assign idx  = full[IW-1:0];
endmodule

// File: rtl/iotx_table.sv
module iotx_table #(
    parameter int EW = iotx_pkg::ENT_W,
    parameter int IW = iotx_pkg::IDX_W
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [EW-1:0] wdata,
    input  logic [IW-1:0] lidx,
    output logic [EW-1:0] ldata,
    input  logic [IW-1:0] ridx,
    output logic [EW-1:0] rdata
);
    localparam int DEPTH = 1 << IW;
    logic [EW-1:0] mem [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_ent
            always_ff @(posedge clk) begin
                if (clr)
                    mem[i] <= '0;
                else if (we && widx == IW'(i))
                    mem[i] <= wdata;
            end
        end
    endgenerate

    // a same-cycle write forwards to the lookup port (R9)
    assign ldata = (we && widx == lidx) ? wdata : mem[lidx];
    assign rdata = mem[ridx];
endmodule

// File: rtl/tce_xlate_top.sv
module tce_xlate_top
    import iotx_pkg::*;
#(
    parameter int AW = iotx_pkg::IOA_W,
    parameter int EW = iotx_pkg::ENT_W,
    parameter int IW = iotx_pkg::IDX_W,
    parameter int SW = iotx_pkg::SHIFT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_en,
    input  logic          cfg_dis,
    input  logic [AW-1:0] cfg_base,
    input  logic [SW-1:0] cfg_shift,
    input  logic [IW:0]   cfg_count,
    input  logic          tbl_clr,
    input  logic          lk_valid,
    input  logic          lk_write,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_done,
    output logic [EW-1:0] lk_phys,
    output logic [1:0]    lk_perm,
    output logic          lk_fault,
    input  logic          rg_valid,
    input  logic          rg_wr,
    input  logic [AW-1:0] rg_addr,
    input  logic [EW-1:0] rg_wdata,
    output logic          rg_done,
    output logic          rg_err,
    output logic [EW-1:0] rg_rdata,
    output logic          nt_valid,
    output logic [AW-1:0] nt_page,
    output logic [EW-1:0] nt_phys,
    output logic [EW-1:0] nt_mask,
    output logic [1:0]    nt_perm
);
    localparam int          DEPTH     = 1 << IW;
    localparam logic [IW:0] DEPTH_CNT = (IW+1)'(DEPTH);

    logic [AW-1:0] base_q;
    logic [SW-1:0] shift_q;
    logic [IW:0]   count_q;

    logic [IW-1:0] l_idx, r_idx;
    logic          l_hit, r_hit;
    logic [AW-1:0] l_offs, r_offs;
    logic [EW-1:0] l_ent, r_ent;
    logic [EW-1:0] pmask;
    logic          clr_all, wr_ok;
    xlate_rsp_t    lk_q;

    // window configuration (R2, R11)
    always_ff @(posedge clk) begin
        if (rst || cfg_dis) begin
            base_q  <= '0;
            shift_q <= '0;
            count_q <= '0;
        end else if (cfg_en && count_q == '0) begin
            base_q  <= cfg_base;
            shift_q <= cfg_shift;
            count_q <= (cfg_count > DEPTH_CNT) ? DEPTH_CNT : cfg_count;
        end
    end

    assign pmask   = page_mask(shift_q);
    assign clr_all = rst || cfg_dis || tbl_clr;
    assign wr_ok   = rg_valid && rg_wr && r_hit && !clr_all;

    iotx_index #(.AW(AW), .IW(IW), .SW(SW), .ALIGN(1'b0)) u_lk_idx (
        .addr(lk_addr), .base(base_q), .shift(shift_q), .count(count_q),
        .idx(l_idx), .hit(l_hit), .offs(l_offs)
    );

    iotx_index #(.AW(AW), .IW(IW), .SW(SW), .ALIGN(1'b1)) u_rg_idx (
        .addr(rg_addr), .base(base_q), .shift(shift_q), .count(count_q),
        .idx(r_idx), .hit(r_hit), .offs(r_offs)
    );

    iotx_table #(.EW(EW), .IW(IW)) u_tbl (
        .clk(clk), .clr(clr_all), .we(wr_ok), .widx(r_idx), .wdata(rg_wdata),
        .lidx(l_idx), .ldata(l_ent), .ridx(r_idx), .rdata(r_ent)
    );

    // lookup pipeline stage (R4, R5)
    always_ff @(posedge clk) begin
        if (rst) begin
            lk_done <= 1'b0;
            lk_q    <= '0;
        end else begin
            lk_done <= lk_valid;
            if (!lk_valid)
                lk_q <= '0;
            else if (!l_hit)
                lk_q <= '{phys: '0, perm: PERM_NONE, fault: 1'b1};
            else
                lk_q <= '{phys: l_ent & pmask, perm: perm_e'(l_ent[1:0]),
                          fault: access_denied(l_ent[1:0], lk_write)};
        end
    end

    assign lk_phys  = lk_q.phys;
    assign lk_perm  = lk_q.perm;
    assign lk_fault = lk_q.fault;

    // single-entry access response (R6, R7) and notification (R8)
    always_ff @(posedge clk) begin
        if (rst) begin
            rg_done  <= 1'b0;
            rg_err   <= 1'b0;
            rg_rdata <= '0;
            nt_valid <= 1'b0;
            nt_page  <= '0;
            nt_phys  <= '0;
            nt_mask  <= '0;
            nt_perm  <= '0;
        end else begin
            rg_done  <= rg_valid;
            rg_err   <= rg_valid && !r_hit;
            rg_rdata <= (rg_valid && !rg_wr && r_hit) ? r_ent : '0;
            nt_valid <= wr_ok;
            if (wr_ok) begin
                nt_page <= r_offs & pmask[AW-1:0];
                nt_phys <= rg_wdata & pmask;
                nt_mask <= ~pmask;
                nt_perm <= rg_wdata[1:0];
            end
        end
    end

    assert_lookup_latency_R4: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> lk_done);
    assert_oob_fault_R5: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !l_hit) |=> (lk_fault && lk_phys == '0 && lk_perm == 2'd0));
    assert_notify_only_ok_R8: assert property (@(posedge clk) disable iff (rst)
        nt_valid |-> (rg_done && !rg_err));
    assert_enable_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (count_q != '0 && !cfg_dis) |=> $stable(count_q));
    assert_disable_clears_R11: assert property (@(posedge clk) disable iff (rst)
        cfg_dis |=> (count_q == '0 && shift_q == '0 && base_q == '0));
    assert_count_cap_R2: assert property (@(posedge clk) disable iff (rst)
        count_q <= DEPTH_CNT);
endmodule

// File: tb/tce_xlate_top_test.sv
`timescale 1ns/1ps
module tce_xlate_top_test;
    localparam int AW = 32, EW = 64, IW = 6, SW = 5, DEPTH = 64;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_en = 0, cfg_dis = 0, tbl_clr = 0;
    logic [AW-1:0] cfg_base = '0;
    logic [SW-1:0] cfg_shift = '0;
    logic [IW:0]   cfg_count = '0;
    logic lk_valid = 0, lk_write = 0;
    logic [AW-1:0] lk_addr = '0;
    logic lk_done, lk_fault;
    logic [EW-1:0] lk_phys;
    logic [1:0] lk_perm;
    logic rg_valid = 0, rg_wr = 0;
    logic [AW-1:0] rg_addr = '0;
    logic [EW-1:0] rg_wdata = '0;
    logic rg_done, rg_err, nt_valid;
    logic [EW-1:0] rg_rdata, nt_phys, nt_mask;
    logic [AW-1:0] nt_page;
    logic [1:0] nt_perm;

    int n_tests = 0, n_fail = 0;

    // bench model
    logic [EW-1:0] m_tbl [DEPTH];
    logic [AW-1:0] m_base = '0;
    logic [SW-1:0] m_shift = '0;
    int            m_count = 0;

    always #2 clk = ~clk;

    tce_xlate_top uut (.*);

    function automatic logic [EW-1:0] f_pmask(input logic [SW-1:0] sh);
        return ~((64'd1 << sh) - 64'd1);
    endfunction
    function automatic logic [AW-1:0] f_full(input logic [AW-1:0] a);
        return (a - m_base) >> m_shift;
    endfunction
    function automatic logic f_hit(input logic [AW-1:0] a);
        return f_full(a) < AW'(m_count);
    endfunction
    function automatic logic [AW-1:0] f_align(input logic [AW-1:0] a);
        return a & f_pmask(m_shift)[AW-1:0];
    endfunction

    task automatic check(input string req, input logic [EW-1:0] act, input logic [EW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        cfg_en = 0; cfg_dis = 0; tbl_clr = 0; lk_valid = 0; rg_valid = 0; rg_wr = 0;
    endtask

    task automatic enable(input logic [AW-1:0] b, input logic [SW-1:0] s, input int c);
        cfg_en = 1; cfg_base = b; cfg_shift = s; cfg_count = (IW+1)'(c);
        if (m_count == 0) begin
            m_base = b; m_shift = s; m_count = (c > DEPTH) ? DEPTH : c;
        end
        step(); idle();
    endtask

    task automatic model_clear_tbl();
        for (int i = 0; i < DEPTH; i++) m_tbl[i] = '0;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [EW-1:0] d, input string req);
        logic h;
        logic [AW-1:0] al;
        logic [EW-1:0] pm;
        h = f_hit(f_align(a)); al = f_align(a); pm = f_pmask(m_shift);
        rg_valid = 1; rg_wr = 1; rg_addr = a; rg_wdata = d;
        step(); idle();
        check({req, " R6 done"}, EW'(rg_done), 1);
        check({req, " R6 err"}, EW'(rg_err), EW'(!h));
        check({req, " R8 nt_valid"}, EW'(nt_valid), EW'(h));
        if (h) begin
            m_tbl[f_full(al)[IW-1:0]] = d;
            check({req, " R8 nt_page"}, EW'(nt_page), EW'((al - m_base) & pm[AW-1:0]));
            check({req, " R8 nt_phys"}, nt_phys, d & pm);
            check({req, " R8 nt_mask"}, nt_mask, ~pm);
            check({req, " R8 nt_perm"}, EW'(nt_perm), EW'(d[1:0]));
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string req);
        logic h;
        logic [EW-1:0] e;
        h = f_hit(f_align(a));
        e = h ? m_tbl[f_full(f_align(a))[IW-1:0]] : '0;
        rg_valid = 1; rg_wr = 0; rg_addr = a;
        step(); idle();
        check({req, " R7 err"}, EW'(rg_err), EW'(!h));
        check({req, " R7 rdata"}, rg_rdata, e);
    endtask

    task automatic exp_lookup(input logic [AW-1:0] a, input logic w, input string req);
        logic h;
        logic [EW-1:0] e;
        h = f_hit(a);
        e = h ? m_tbl[f_full(a)[IW-1:0]] : '0;
        check({req, " R4 done"}, EW'(lk_done), 1);
        check({req, " R4 phys"}, lk_phys, h ? (e & f_pmask(m_shift)) : '0);
        check({req, " R4 perm"}, EW'(lk_perm), h ? EW'(e[1:0]) : 0);
        check({req, " R5 fault"}, EW'(lk_fault), !h ? 1 : (w ? EW'(!e[1]) : EW'(!e[0])));
    endtask

    task automatic do_lookup(input logic [AW-1:0] a, input logic w, input string req);
        lk_valid = 1; lk_write = w; lk_addr = a;
        step(); idle();
        exp_lookup(a, w, req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [AW-1:0] a;
        logic [EW-1:0] d;
        void'($urandom(32'h5eed_1234));
        model_clear_tbl();
        repeat (3) step();
        rst = 0;
        // R1 reset state
        check("R1 lk_done", EW'(lk_done), 0);
        check("R1 rg_done", EW'(rg_done), 0);
        check("R1 nt_valid", EW'(nt_valid), 0);
        do_lookup(32'h0, 0, "R1 lookup no table");

        // R2 enable: base 0x10000, 4 KiB pages, 16 entries
        enable(32'h0001_0000, 5'd12, 16);
        do_read(32'h0001_0000, "R1 entry zero after enable");

        // R6/R8 writes, one per permission code
        do_write(32'h0001_0000, 64'h0000_0001_2345_6000, "R6 perm none");
        do_write(32'h0001_1000, 64'h0000_0002_0000_7001, "R6 perm ro");
        do_write(32'h0001_2000, 64'h0000_0003_0000_8002, "R6 perm wo");
        do_write(32'h0001_3abc, 64'h0000_0004_0000_9fff, "R6 unaligned rw");
        // R3/R5 lookups, both access types
        for (int i = 0; i < 4; i++) begin
            do_lookup(32'h0001_0000 + 32'(i) * 32'h1000 + 32'h77, 0, "R5 read access");
            do_lookup(32'h0001_0000 + 32'(i) * 32'h1000 + 32'h77, 1, "R5 write access");
        end
        // R3 window edges
        do_lookup(32'h0001_0000 + 32'd16 * 32'h1000, 0, "R3 index == count");
        do_lookup(32'h0000_ffff, 0, "R3 below base");
        do_lookup(32'h0001_ffff, 0, "R3 last entry");
        do_write(32'h0001_0000 + 32'd16 * 32'h1000, 64'hdead_b003, "R6 out of range");
        do_read(32'h0001_0000 + 32'd16 * 32'h1000, "R7 out of range");
        do_read(32'h0001_3000, "R7 read back");

        // R2 second enable ignored: count stays 16
        enable(32'h0, 5'd12, 40);
        do_lookup(32'h0001_0000 + 32'd20 * 32'h1000, 0, "R2 enable ignored");
        do_read(32'h0001_1000, "R2 base kept");

        // R9 same-cycle lookup and write to the same index
        rg_valid = 1; rg_wr = 1; rg_addr = 32'h0001_5000; rg_wdata = 64'h0000_00aa_0000_b003;
        lk_valid = 1; lk_write = 1; lk_addr = 32'h0001_5123;
        m_tbl[5] = 64'h0000_00aa_0000_b003;
        step(); idle();
        exp_lookup(32'h0001_5123, 1, "R9 write forwarded");
        check("R9 write done", EW'(rg_err), 0);

        // R10 clear keeps config
        tbl_clr = 1; step(); idle(); model_clear_tbl();
        do_read(32'h0001_5000, "R10 entry cleared");
        do_lookup(32'h0001_5000, 0, "R10 lookup after clear");
        do_write(32'h0001_f000, 64'h0000_0010_0000_0003, "R10 config kept");

        // R11 disable
        cfg_dis = 1; step(); idle();
        model_clear_tbl(); m_base = '0; m_shift = '0; m_count = 0;
        do_read(32'h0001_f000, "R11 disabled read");
        do_lookup(32'h0, 0, "R11 disabled lookup");
        do_read(32'h0, "R11 disabled addr zero");

        // R2 cap, then random traffic in a 64 KiB-page window
        enable(32'h0040_0800, 5'd16, 100);
        do_lookup(32'h0040_0800 + 32'd63 * 32'h1_0000, 0, "R2 count capped in");
        do_lookup(32'h0040_0800 + 32'd64 * 32'h1_0000, 0, "R2 count capped out");
        for (int k = 0; k < 300; k++) begin
            a = 32'h0030_0000 + ($urandom % 32'h0060_0000);
            d = {$urandom, $urandom};
            case ($urandom % 3)
                0: do_write(a, d, "R6 random write");
                1: do_read(a, "R7 random read");
                default: do_lookup(a, 1'($urandom), "R4 random lookup");
            endcase
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule